// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

A 32-pin general-purpose I/O bank with a flat word-addressed register port. Software sets per-pin direction, output value, blink gating and input polarity. Each pin's input passes through a two-flop synchronizer and is then XORed with its polarity bit. The result can be read back and feeds both interrupt paths, so one polarity setting chooses active-high or active-low for level interrupts and rising or falling for edge interrupts.

Each pin can raise an interrupt in two ways. A level cause is the polarity-adjusted input gated by a level-mask bit. An edge cause is a sticky bit that is set when the adjusted input goes from 0 to 1, and it counts only when its edge-mask bit is set. Software clears edge causes by writing a 0 to each bit it wants to clear. The combined per-pin causes are ORed in blocks of eight pins into four interrupt outputs. The pad drivers appear as an output-enable vector and an output-value vector. Blink timing comes from an external toggle reference.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, output data, blink enable, input polarity, edge cause, edge mask and level mask are all zero, and the direction register is all ones (every pin an input). All `irq_out` bits are 0 and `pad_oe` is all zero.
- R2: The byte offsets are: 0x00 output data, 0x04 direction, 0x08 blink enable, 0x0C input polarity, 0x10 data-in (read-only), 0x14 edge cause, 0x18 edge mask, 0x1C level mask.
  - A write is sampled at the rising clock edge where `reg_we` is high. After that edge, the read-write registers return the value written.
  - A read of any other offset returns 0.
  - A write to 0x10 has no effect.
- R3: Direction bit 1 makes a pin an input and bit 0 makes it an output, so `pad_oe[i]` is the inverse of direction bit i. An output pin with blink disabled drives `pad_out[i]` equal to output data bit i.
- R4: When blink-enable bit i is 1, `pad_out[i]` equals output data bit i ANDed with `blink_tick`. When it is 0, `pad_out[i]` equals the output data bit.
- R5: Data-in bit i reads as `pin_in[i]` XOR polarity bit i. A change on `pin_in` appears there after two rising clock edges.
- R6: The level cause of pin i is its data-in bit ANDed with level-mask bit i.
  - `irq_out[g]` is the OR of the combined causes of pins 8g to 8g+7.
  - A level cause reaches `irq_out` two rising edges after the pin changes.
- R7: Edge-cause bit i is set on the rising edge that follows a 0-to-1 change of data-in bit i. With polarity 0 this captures rising pin edges; with polarity 1 it captures falling pin edges. The opposite edge sets nothing, and a set bit stays set until software clears it.
- R8: A write to the edge-cause offset clears every bit written as 0 and leaves every bit written as 1 unchanged. Writing all zeros clears every pending bit.
- R9: An edge-cause bit contributes to `irq_out` only while its edge-mask bit is 1.
- R10: If a new edge and a clearing write hit the same edge-cause bit on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| blink_tick | input | 1 | Free-running blink toggle reference |
| pad_oe | output | 32 | Pad output enable, 1 = drive |
| pad_out | output | 32 | Pad output value |
| irq_out | output | 4 | Grouped interrupt lines, one per eight pins |

## Verification
The hardest situation to reach from the ports is a software clear that lands on the exact clock edge where a new edge is captured. The input first passes through two synchronizer flops and then the edge detector, so a pin change sets the cause only on the third rising edge. The stimulus counts those edges: it toggles a pin at a falling edge, waits two falling edges, and then asserts an all-zero write to the edge-cause offset. That write is sampled together with the capture. A second, older pending bit shows that the same write still clears everything else. Polarity-dependent edges are swept over every pin in both polarities. Each pin's grouping is swept one pin at a time.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register offsets and register-select decode for the
// GPIO bank. Assumes byte addressing with 32-bit registers on 4-byte
// boundaries.
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_BLINK = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_POL   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EMASK = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LMASK = 8'h1C;

    typedef enum logic [3:0] {
        SEL_OUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_DIN,
        SEL_CAUSE,
        SEL_EMASK,
        SEL_LMASK,
        SEL_NONE
    } reg_sel_e;

    // Map a byte offset onto a register select; unmapped offsets give SEL_NONE.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_OUT:   s = SEL_OUT;
            OFS_DIR:   s = SEL_DIR;
            OFS_BLINK: s = SEL_BLINK;
            OFS_POL:   s = SEL_POL;
            OFS_DIN:   s = SEL_DIN;
            OFS_CAUSE: s = SEL_CAUSE;
            OFS_EMASK: s = SEL_EMASK;
            OFS_LMASK: s = SEL_LMASK;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds the six software-written configuration registers of the bank:
// output data, direction, blink enable, input polarity, edge mask and
// level mask. Assumes the caller has already decoded the address into a
// register select. A write lands on the rising edge where wr_en is high.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] blink_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] emask_q,
    output logic [NUM_PINS-1:0] lmask_q
);

    localparam logic [NUM_PINS-1:0] ALL_IN = '1;

    // Output data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          out_q <= '0;
        else if (wr_en && wr_sel == SEL_OUT) out_q <= wr_data;
    end

    // Direction register: 1 = input, resets with every pin as an input.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= ALL_IN;
        else if (wr_en && wr_sel == SEL_DIR) dir_q <= wr_data;
    end

    // Blink enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            blink_q <= '0;
        else if (wr_en && wr_sel == SEL_BLINK) blink_q <= wr_data;
    end

    // Input polarity register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pol_q <= '0;
        else if (wr_en && wr_sel == SEL_POL) pol_q <= wr_data;
    end

    // Edge interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            emask_q <= '0;
        else if (wr_en && wr_sel == SEL_EMASK) emask_q <= wr_data;
    end

    // Level interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            lmask_q <= '0;
        else if (wr_en && wr_sel == SEL_LMASK) lmask_q <= wr_data;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Brings asynchronous pin levels into the clock domain with two flops,
// applies the per-pin polarity inversion and flags 0-to-1 transitions of
// the adjusted value. Assumes each pin is an independent signal; no
// cross-pin coherence is provided.
module gpio_in_sync #(
    parameter int NUM_PINS  = 32,
    parameter int SYNC_LVLS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pol,
    output logic [NUM_PINS-1:0] adj,
    output logic [NUM_PINS-1:0] rise
);

    logic [NUM_PINS-1:0] sync_q [SYNC_LVLS];
    logic [NUM_PINS-1:0] prev_q;

    // Synchronizer chain: stage 0 samples the pins, later stages follow it.
    generate
        for (genvar s = 0; s < SYNC_LVLS; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)      sync_q[s] <= '0;
                else if (s == 0) sync_q[s] <= pin_in;
                else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign adj  = sync_q[SYNC_LVLS-1] ^ pol;
    assign rise = adj & ~prev_q;

    // Previous adjusted value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= adj;
    end

endmodule

// File: rtl/gpio_edge_cause.sv
// Module: gpio_edge_cause
// Sticky edge-cause register. A bit is set by a detected edge and cleared
// by a software write carrying a 0 in that bit. Assumes clr_en is high only
// for a write to the cause offset. A new edge beats a clear on the same cycle.
module gpio_edge_cause #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] rise,
    input  logic                clr_en,
    input  logic [NUM_PINS-1:0] clr_data,
    output logic [NUM_PINS-1:0] cause_q
);

    logic [NUM_PINS-1:0] keep;

    assign keep = clr_en ? clr_data : '1;

    // Keep the surviving bits, then OR in the new edges so edges win.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & keep) | rise;
    end

endmodule

// File: rtl/gpio_irq_group.sv
// Module: gpio_irq_group
// Combines level and masked edge causes per pin and ORs each block of
// GROUP_SIZE pins into one interrupt line. Purely combinational. Assumes
// NUM_PINS is a multiple of GROUP_SIZE.
module gpio_irq_group #(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_SIZE = 8,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
    input  logic [NUM_PINS-1:0]   adj,
    input  logic [NUM_PINS-1:0]   lmask,
    input  logic [NUM_PINS-1:0]   cause,
    input  logic [NUM_PINS-1:0]   emask,
    output logic [NUM_GROUPS-1:0] irq
);

    logic [NUM_PINS-1:0] pin_cause;

    assign pin_cause = (adj & lmask) | (cause & emask);

    // One OR-reduction per group of pins.
    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign irq[g] = |pin_cause[g*GROUP_SIZE +: GROUP_SIZE];
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_bank.sv
// Module: gpio_irq_bank (top)
// GPIO bank: configuration registers, synchronized and polarity-adjusted
// inputs, sticky edge causes, pad drive with blink gating and grouped
// interrupt outputs. Assumes a single-cycle register port with combinational
// read data. Write data is as wide as the pin count.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_SIZE = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_we,
    input  logic [NUM_PINS-1:0]            reg_wdata,
    output logic [NUM_PINS-1:0]            reg_rdata,
    input  logic [NUM_PINS-1:0]            pin_in,
    input  logic                           blink_tick,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS/GROUP_SIZE-1:0] irq_out
);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] out_q, dir_q, blink_q, pol_q;
    logic [NUM_PINS-1:0] edge_mask, level_mask;
    logic [NUM_PINS-1:0] adj_vec, rise_vec, cause_q;
    logic                cause_clr;

    assign sel       = decode_addr(reg_addr);
    assign cause_clr = reg_we && (sel == SEL_CAUSE);

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_sel  (sel),
        .wr_data (reg_wdata),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .blink_q (blink_q),
        .pol_q   (pol_q),
        .emask_q (edge_mask),
        .lmask_q (level_mask)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_LVLS(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .pol    (pol_q),
        .adj    (adj_vec),
        .rise   (rise_vec)
    );

    gpio_edge_cause #(.NUM_PINS(NUM_PINS)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_vec),
        .clr_en   (cause_clr),
        .clr_data (reg_wdata),
        .cause_q  (cause_q)
    );

    gpio_irq_group #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_irq (
        .adj   (adj_vec),
        .lmask (level_mask),
        .cause (cause_q),
        .emask (edge_mask),
        .irq   (irq_out)
    );

    // Pad drive per pin: enable from direction, value gated by blink.
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
            assign pad_oe[i]  = ~dir_q[i];
            assign pad_out[i] = out_q[i] & (~blink_q[i] | blink_tick);
        end
    endgenerate

    // Read-back multiplexer; unmapped offsets read as zero.
    always_comb begin
        case (sel)
            SEL_OUT:   reg_rdata = out_q;
            SEL_DIR:   reg_rdata = dir_q;
            SEL_BLINK: reg_rdata = blink_q;
            SEL_POL:   reg_rdata = pol_q;
            SEL_DIN:   reg_rdata = adj_vec;
            SEL_CAUSE: reg_rdata = cause_q;
            SEL_EMASK: reg_rdata = edge_mask;
            SEL_LMASK: reg_rdata = level_mask;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Module: gpio_irq_bank_chk
// Property checker bound into gpio_irq_bank. Observes ports plus the
// edge-cause state, edge detections and masks of the bank.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_SIZE = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic                           reg_we,
    input logic [NUM_PINS-1:0]            reg_wdata,
    input logic [NUM_PINS-1:0]            pad_oe,
    input logic [NUM_PINS/GROUP_SIZE-1:0] irq_out,
    input logic [NUM_PINS-1:0]            cause_q,
    input logic [NUM_PINS-1:0]            rise_vec,
    input logic [NUM_PINS-1:0]            edge_mask,
    input logic [NUM_PINS-1:0]            level_mask
);

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_DIR) |=> (pad_oe == ~$past(reg_wdata))); // R3

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == OFS_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CAUSE && reg_wdata == '0) |=> (cause_q == $past(rise_vec))); // R8

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vec != '0) |=> ((cause_q & $past(rise_vec)) == $past(rise_vec))); // R10

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mask == '0 && level_mask == '0) |-> (irq_out == '0)); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .NUM_PINS   (NUM_PINS),
    .GROUP_SIZE (GROUP_SIZE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .pad_oe     (pad_oe),
    .irq_out    (irq_out),
    .cause_q    (cause_q),
    .rise_vec   (rise_vec),
    .edge_mask  (edge_mask),
    .level_mask (level_mask)
);

// File: tb/gpio_irq_bank_test.sv
// Bench for gpio_irq_bank: sweeps registers, pins and polarities, with
// expected values computed from the requirements.
module gpio_irq_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic        blink_tick = 1'b0;
    logic [31:0] pad_oe, pad_out;
    logic [3:0]  irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .blink_tick(blink_tick), .pad_oe(pad_oe), .pad_out(pad_out),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; the write is sampled on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [5];
        logic [7:0]  rw_ofs [6];
        pats[0] = 32'hA5A5_A5A5; pats[1] = 32'h5A5A_5A5A; pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h0000_0000; pats[4] = 32'h1234_5678;
        rw_ofs[0] = 8'h00; rw_ofs[1] = 8'h04; rw_ofs[2] = 8'h08;
        rw_ofs[3] = 8'h0C; rw_ofs[4] = 8'h18; rw_ofs[5] = 8'h1C;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1: reset state
        rd_chk("R1 out",   8'h00, 32'h0);
        rd_chk("R1 dir",   8'h04, 32'hFFFF_FFFF);
        rd_chk("R1 blink", 8'h08, 32'h0);
        rd_chk("R1 pol",   8'h0C, 32'h0);
        rd_chk("R1 cause", 8'h14, 32'h0);
        rd_chk("R1 emask", 8'h18, 32'h0);
        rd_chk("R1 lmask", 8'h1C, 32'h0);
        chk("R1 irq", {28'h0, irq_out}, 32'h0);
        chk("R1 oe", pad_oe, 32'h0);

        // R2: read-back of every read-write register, unmapped offsets, read-only data-in
        foreach (rw_ofs[r]) begin
            for (int p = 0; p < 5; p++) begin
                wr(rw_ofs[r], pats[p]);
                rd_chk("R2 readback", rw_ofs[r], pats[p]);
            end
        end
        wr(8'h0C, 32'h0);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0);
        wait_n(3);
        wr(8'h14, 32'h0);
        rd_chk("R2 unmapped 20", 8'h20, 32'h0);
        rd_chk("R2 unmapped 03", 8'h03, 32'h0);
        rd_chk("R2 unmapped FC", 8'hFC, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R2 din write ignored", 8'h10, 32'h0);

        // R3/R4: pad drive across direction, data, blink and tick patterns
        for (int p = 0; p < 5; p++) begin
            wr(8'h04, pats[(p + 1) % 5]);
            wr(8'h00, pats[p]);
            wr(8'h08, pats[(p + 3) % 5]);
            for (int t = 0; t < 2; t++) begin
                blink_tick = t[0];
                #1;
                chk("R3 oe", pad_oe, ~pats[(p + 1) % 5]);
                chk("R4 blink out", pad_out, pats[p] & (~pats[(p + 3) % 5] | {32{t[0]}}));
            end
        end
        wr(8'h08, 32'h0);
        #1;
        chk("R3 plain out", pad_out, pats[4]);
        blink_tick = 1'b0;

        // R5: data-in equals pin XOR polarity after two edges
        for (int p = 0; p < 5; p++) begin
            wr(8'h0C, pats[(p + 2) % 5]);
            pin_in = pats[p];
            wait_n(1);
            wait_n(1);
            rd_chk("R5 din", 8'h10, pats[p] ^ pats[(p + 2) % 5]);
        end
        pin_in = '0;
        wr(8'h0C, 32'h0);
        wait_n(3);
        wr(8'h14, 32'h0);

        // R6: level interrupt grouping, pin by pin
        wr(8'h1C, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            pin_in = 32'h1 << i;
            wait_n(2);
            chk("R6 level group", {28'h0, irq_out}, 32'h1 << (i / 8));
            pin_in = '0;
            wait_n(2);
        end
        chk("R6 level idle", {28'h0, irq_out}, 32'h0);
        wr(8'h1C, 32'h0000_FF00);
        pin_in = 32'h0000_00FF;
        wait_n(2);
        chk("R6 level masked", {28'h0, irq_out}, 32'h0);
        pin_in = '0;
        wr(8'h1C, 32'h0);
        wait_n(3);
        wr(8'h14, 32'h0);

        // R7: rising edges with polarity 0, falling ignored
        for (int i = 0; i < 32; i++) begin
            pin_in = 32'h1 << i;
            wait_n(3);
            rd_chk("R7 rising cause", 8'h14, 32'h1 << i);
            wr(8'h14, ~(32'h1 << i));
            rd_chk("R8 single clear", 8'h14, 32'h0);
            pin_in = '0;
            wait_n(3);
            rd_chk("R7 falling ignored pol0", 8'h14, 32'h0);
        end

        // R7: falling edges with polarity 1
        pin_in = 32'hFFFF_FFFF;
        wait_n(3);
        wr(8'h0C, 32'hFFFF_FFFF);
        wait_n(3);
        wr(8'h14, 32'h0);
        for (int i = 0; i < 32; i++) begin
            pin_in = ~(32'h1 << i);
            wait_n(3);
            rd_chk("R7 falling cause", 8'h14, 32'h1 << i);
            pin_in = 32'hFFFF_FFFF;
            wait_n(3);
            rd_chk("R7 rising ignored pol1", 8'h14, 32'h1 << i);
            wr(8'h14, 32'h0);
        end
        wr(8'h0C, 32'h0);
        pin_in = '0;
        wait_n(3);
        wr(8'h14, 32'h0);

        // R8: clear only bits written as 0
        pin_in = 32'h0000_000F;
        wait_n(3);
        rd_chk("R8 four set", 8'h14, 32'h0000_000F);
        wr(8'h14, 32'hFFFF_FFF5);
        rd_chk("R8 partial clear", 8'h14, 32'h0000_0005);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R8 ones keep", 8'h14, 32'h0000_0005);
        wr(8'h14, 32'h0);
        rd_chk("R8 zero clear all", 8'h14, 32'h0);
        pin_in = '0;
        wait_n(3);

        // R9: edge mask gating
        pin_in = 32'h0000_0200;
        wait_n(3);
        chk("R9 unmasked edge quiet", {28'h0, irq_out}, 32'h0);
        wr(8'h18, 32'h0000_0200);
        chk("R9 masked edge irq", {28'h0, irq_out}, 32'h2);
        wr(8'h18, 32'h0000_0100);
        chk("R9 other mask quiet", {28'h0, irq_out}, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h14, 32'h0);
        chk("R9 cleared quiet", {28'h0, irq_out}, 32'h0);
        wr(8'h18, 32'h0);
        pin_in = '0;
        wait_n(3);

        // R10: clear and new edge on the same rising edge
        pin_in = 32'h0000_0004;
        wait_n(3);
        rd_chk("R10 old pending", 8'h14, 32'h0000_0004);
        pin_in = 32'h0000_0024;
        wait_n(2);
        wr(8'h14, 32'h0);
        rd_chk("R10 edge wins", 8'h14, 32'h0000_0020);
        wr(8'h14, 32'h0);
        rd_chk("R10 later clear", 8'h14, 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule